// File: doc/BRIEF.md
# Sync-Latched Control Register Bank

This block holds a small set of control registers and one status register, all reached by an 8-bit subaddress over a byte-wide host bus. A host transfer opens with a start strobe that carries the subaddress. Each write or read strobe after that moves one data byte. A 16-bit register takes two bytes, high byte first. Bytes of a write are staged and become a single word only when the second byte arrives.

Each register has one access mode: write/read, write-only or read-only. Some control registers drive their outputs at once. Others keep the written value in a shadow copy, which passes to the output only on a vertical or a horizontal sync pulse. Readback of a write/read register returns the value most recently written, even before any sync pulse.

The read-only status register reports lower and upper black-line counts and a black-picture flag. The line-measurement logic outside the block updates these counts. Reading the first byte of the status register captures the whole word and restarts both counts at 127.

Register map:

| Subaddress | Output | Access | Bytes | Bits kept | Takes effect |
|---|---|---|---|---|---|
| 0x04 | `mode_o` | write/read | 1 | 8 | at once |
| 0x05 | `gain_o` | write/read | 2 | 12 | vertical sync |
| 0x06 | `offs_o` | write-only | 2 | 9 | horizontal sync |
| 0x07 | `sel_o` | write/read | 1 | 5 | horizontal sync |
| 0x0C | status | read-only | 2 | 15 | n/a |

Top module: `sync_reg_bank`

## Requirements
- R1: After reset, all control outputs are 0, both line counts are 127 and `hst_rdata_o` is 0.
- R2: A 16-bit register (0x05, 0x06) takes its high byte first and its low byte second. Neither its output nor its readback changes until the second byte has been written.
- R3: Bits above a register's kept width are dropped on write and read back as 0. Examples: 0x05 reads back {4'b0, bits[11:0]}, and 0x07 reads back {3'b0, bits[4:0]}.
- R4: Register 0x04 drives `mode_o` with the written byte on the clock edge that accepts the write.
- R5: `gain_o` (0x05) changes only on a `vsync_i` pulse. On that pulse it loads the most recently written value. `hsync_i` has no effect on it.
- R6: `offs_o` (0x06) and `sel_o` (0x07) change only on an `hsync_i` pulse, and `vsync_i` has no effect on them.
- R7: Reading a write/read register returns its last written value, whether or not a sync pulse has occurred. Reads of the write-only register 0x06 and of unmapped subaddresses return 0. Read data appears on `hst_rdata_o` one edge after the read strobe.
- R8: The status word at 0x0C holds the lower count in bits [6:0], 0 in bit 7, the upper count in bits [14:8] and the black-picture flag in bit 15. Its high byte is read first.
- R9: Reading the first status byte captures the whole word and sets both counts to 127. The second byte returns the captured low byte, even if the counts change in between.
- R10: Writes to the read-only status subaddress and to unmapped subaddresses change no register and no count.
- R11: A start strobe resets the byte position. A 16-bit write cut off after one byte commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_start_i | input | 1 | Opens a transfer at `hst_addr_i` |
| hst_addr_i | input | 8 | Subaddress |
| hst_wr_i | input | 1 | Write one data byte |
| hst_wdata_i | input | 8 | Write byte |
| hst_rd_i | input | 1 | Read one data byte |
| hst_rdata_o | output | 8 | Read byte, valid one edge after the read strobe |
| vsync_i | input | 1 | Vertical sync pulse |
| hsync_i | input | 1 | Horizontal sync pulse |
| blk_upd_i | input | 1 | Load new line counts from the measurement logic |
| blk_low_i | input | 7 | New lower black-line count |
| blk_up_i | input | 7 | New upper black-line count |
| blk_pic_i | input | 1 | Black-picture flag |
| blk_low_o | output | 7 | Current lower count |
| blk_up_o | output | 7 | Current upper count |
| mode_o | output | 8 | Register 0x04 |
| gain_o | output | 12 | Register 0x05, vertical-sync latched |
| offs_o | output | 9 | Register 0x06, horizontal-sync latched |
| sel_o | output | 5 | Register 0x07, horizontal-sync latched |

## Verification
The bench writes the sync-latched registers and then pulses the wrong sync, then the right one. A design that latched on the wrong event, or passed writes straight through, would move `gain_o` or `offs_o` too early. It loads new counts between the two bytes of a status read. A design that re-sampled the word on the second byte would return the new low count instead of the captured one. A design that did not reload the counts would show stale values after the first byte. It also cuts off a 16-bit write after one byte and restarts it, writes all-ones to narrow registers, and writes to the read-only and unmapped subaddresses. These expose a commit on a lone byte, leaked upper bits, and decode that lets writes reach the wrong place.

// File: rtl/lbank_pkg.sv
package lbank_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 2 * BYTE_W;
  localparam int unsigned CNT_W   = 7;
  localparam int unsigned NUM_CTL = 4;

  typedef enum logic [1:0] {LAT_NONE, LAT_V, LAT_H} latch_e;

  localparam logic [ADDR_W-1:0] CTL_ADDR [NUM_CTL] = '{8'h04, 8'h05, 8'h06, 8'h07};
  localparam int unsigned       CTL_BITS [NUM_CTL] = '{8, 12, 9, 5};
  localparam bit                CTL_WIDE [NUM_CTL] = '{1'b0, 1'b1, 1'b1, 1'b0};
  localparam bit                CTL_RDBK [NUM_CTL] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam latch_e            CTL_LAT  [NUM_CTL] = '{LAT_NONE, LAT_V, LAT_H, LAT_H};

  localparam logic [ADDR_W-1:0] STAT_ADDR  = 8'h0C;
  localparam logic [CNT_W-1:0]  CNT_RELOAD = '1;
endpackage

// File: rtl/sreg_seq.sv
module sreg_seq import lbank_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              cur_wide_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              idx_o,
  output logic              wr_commit_o,
  output logic [WORD_W-1:0] wr_word_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              idx_q;
  logic [BYTE_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      idx_q   <= 1'b0;
      stage_q <= '0;
    end else if (start_i) begin
      addr_q <= addr_i;
      idx_q  <= 1'b0;
    end else if (wr_i || rd_i) begin
      if (wr_i && !idx_q) stage_q <= wdata_i;
      idx_q <= cur_wide_i ? ~idx_q : 1'b0;
    end
  end

  // a wide register commits only on its second byte
  assign wr_commit_o = wr_i && !start_i && (!cur_wide_i || idx_q);
  assign wr_word_o   = cur_wide_i ? {stage_q, wdata_i} : {{BYTE_W{1'b0}}, wdata_i};
  assign addr_o      = addr_q;
  assign idx_o       = idx_q;

  p_start_rewind_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (idx_q == 1'b0) && (addr_q == $past(addr_i)));
  p_narrow_no_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && (wr_i || rd_i) && !cur_wide_i) |=> !idx_q);
endmodule

// File: rtl/sreg_cell.sv
module sreg_cell import lbank_pkg::*; #(
  parameter int unsigned WIDTH = 8,
  parameter latch_e      LATCH = LAT_NONE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             vsync_i,
  input  logic             hsync_i,
  output logic [WIDTH-1:0] shadow_o,
  output logic [WIDTH-1:0] value_o
);
  logic [WIDTH-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shadow_q <= '0;
    else if (commit_i) shadow_q <= wdata_i;
  end
  assign shadow_o = shadow_q;

  p_commit_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> shadow_q == $past(wdata_i));

  if (LATCH == LAT_NONE) begin : g_direct
    logic unused_sync;
    assign unused_sync = vsync_i ^ hsync_i;
    assign value_o = shadow_q;
  end else begin : g_sync
    logic             tick;
    logic [WIDTH-1:0] value_q;
    assign tick = (LATCH == LAT_V) ? vsync_i : hsync_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   value_q <= '0;
      else if (tick) value_q <= shadow_q;
    end
    assign value_o = value_q;

    // R6 shares these for the horizontal variant
    p_sync_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick |=> $stable(value_q));
    p_sync_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick |=> value_q == $past(shadow_q));
  end
endmodule

// File: rtl/sreg_linestat.sv
module sreg_linestat import lbank_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [CNT_W-1:0]  low_i,
  input  logic [CNT_W-1:0]  up_i,
  input  logic              pic_i,
  output logic [CNT_W-1:0]  low_o,
  output logic [CNT_W-1:0]  up_o,
  output logic [WORD_W-1:0] word_o
);
  logic [CNT_W-1:0] low_q, up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= CNT_RELOAD;
      up_q  <= CNT_RELOAD;
    end else if (clr_i) begin
      low_q <= CNT_RELOAD;
      up_q  <= CNT_RELOAD;
    end else if (upd_i) begin
      low_q <= low_i;
      up_q  <= up_i;
    end
  end

  assign low_o  = low_q;
  assign up_o   = up_q;
  assign word_o = {pic_i, up_q, 1'b0, low_q};

  p_read_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (low_q == CNT_RELOAD) && (up_q == CNT_RELOAD));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i) |=> $stable(low_q) && $stable(up_q));
endmodule

// File: rtl/sync_reg_bank.sv
module sync_reg_bank import lbank_pkg::*; (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hst_start_i,
  input  logic [ADDR_W-1:0]      hst_addr_i,
  input  logic                   hst_wr_i,
  input  logic [BYTE_W-1:0]      hst_wdata_i,
  input  logic                   hst_rd_i,
  output logic [BYTE_W-1:0]      hst_rdata_o,
  input  logic                   vsync_i,
  input  logic                   hsync_i,
  input  logic                   blk_upd_i,
  input  logic [CNT_W-1:0]       blk_low_i,
  input  logic [CNT_W-1:0]       blk_up_i,
  input  logic                   blk_pic_i,
  output logic [CNT_W-1:0]       blk_low_o,
  output logic [CNT_W-1:0]       blk_up_o,
  output logic [CTL_BITS[0]-1:0] mode_o,
  output logic [CTL_BITS[1]-1:0] gain_o,
  output logic [CTL_BITS[2]-1:0] offs_o,
  output logic [CTL_BITS[3]-1:0] sel_o
);
  logic [ADDR_W-1:0]  addr_q;
  logic               idx_q, cur_wide, wr_commit, stat_hit, rd_fire, stat_clr;
  logic [WORD_W-1:0]  wr_word, rd_word, stat_word;
  logic [NUM_CTL-1:0] hit;
  logic [WORD_W-1:0]  ctl_word [NUM_CTL];
  logic [BYTE_W-1:0]  rdata_q, hold_q;

  sreg_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (hst_start_i),
    .addr_i      (hst_addr_i),
    .wr_i        (hst_wr_i),
    .rd_i        (hst_rd_i),
    .wdata_i     (hst_wdata_i),
    .cur_wide_i  (cur_wide),
    .addr_o      (addr_q),
    .idx_o       (idx_q),
    .wr_commit_o (wr_commit),
    .wr_word_o   (wr_word)
  );

  always_comb begin
    cur_wide = 1'b0;
    rd_word  = '0;
    stat_hit = (addr_q == STAT_ADDR);
    for (int i = 0; i < NUM_CTL; i++) begin
      hit[i] = (addr_q == CTL_ADDR[i]);
      if (hit[i]) begin
        cur_wide = CTL_WIDE[i];
        if (CTL_RDBK[i]) rd_word = ctl_word[i];
      end
    end
    if (stat_hit) begin
      cur_wide = 1'b1;
      rd_word  = stat_word;
    end
  end

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    localparam int unsigned W = CTL_BITS[g];
    logic [W-1:0] shadow, value;
    sreg_cell #(.WIDTH(W), .LATCH(CTL_LAT[g])) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .commit_i (wr_commit && hit[g]),
      .wdata_i  (wr_word[W-1:0]),
      .vsync_i  (vsync_i),
      .hsync_i  (hsync_i),
      .shadow_o (shadow),
      .value_o  (value)
    );
    assign ctl_word[g] = WORD_W'(shadow);
  end

  assign mode_o = g_ctl[0].value;
  assign gain_o = g_ctl[1].value;
  assign offs_o = g_ctl[2].value;
  assign sel_o  = g_ctl[3].value;

  assign rd_fire  = hst_rd_i && !hst_start_i;
  assign stat_clr = rd_fire && stat_hit && !idx_q;

  sreg_linestat u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stat_clr),
    .upd_i  (blk_upd_i),
    .low_i  (blk_low_i),
    .up_i   (blk_up_i),
    .pic_i  (blk_pic_i),
    .low_o  (blk_low_o),
    .up_o   (blk_up_o),
    .word_o (stat_word)
  );

  // first byte snapshots the word; second byte serves the snapshot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      hold_q  <= '0;
    end else if (rd_fire) begin
      if (!idx_q) begin
        hold_q  <= rd_word[BYTE_W-1:0];
        rdata_q <= cur_wide ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
      end else begin
        rdata_q <= hold_q;
      end
    end
  end
  assign hst_rdata_o = rdata_q;

  p_wo_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && hit[2]) |=> hst_rdata_o == '0);
  p_ro_write_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_wr_i && stat_hit && !blk_upd_i && !stat_clr) |=> $stable(blk_low_o) && $stable(blk_up_o));
  p_unmapped_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_wr_i && hit == '0) |=> $stable(mode_o));
  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hst_start_i, hst_wr_i, hst_rd_i}));
endmodule

// File: tb/tb_sync_reg_bank.sv
`timescale 1ns/1ps
module tb_sync_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        vs = 1'b0, hs = 1'b0;
  logic        upd = 1'b0, pic = 1'b0;
  logic [6:0]  low_in = '0, up_in = '0, low_o, up_o;
  logic [7:0]  mode;
  logic [11:0] gain;
  logic [8:0]  offs;
  logic [4:0]  sel;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sync_reg_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .hst_start_i(start), .hst_addr_i(addr),
    .hst_wr_i(wr), .hst_wdata_i(wdata), .hst_rd_i(rd), .hst_rdata_o(rdata),
    .vsync_i(vs), .hsync_i(hs), .blk_upd_i(upd), .blk_low_i(low_in),
    .blk_up_i(up_in), .blk_pic_i(pic), .blk_low_o(low_o), .blk_up_o(up_o),
    .mode_o(mode), .gain_o(gain), .offs_o(offs), .sel_o(sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic h_start(input logic [7:0] a);
    @(negedge clk); start = 1'b1; addr = a;
    @(negedge clk); start = 1'b0;
  endtask
  task automatic h_wr(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask
  task automatic h_rd(output logic [7:0] d);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask
  task automatic p_vs();
    @(negedge clk); vs = 1'b1;
    @(negedge clk); vs = 1'b0;
  endtask
  task automatic p_hs();
    @(negedge clk); hs = 1'b1;
    @(negedge clk); hs = 1'b0;
  endtask
  task automatic p_upd(input logic [6:0] lo, input logic [6:0] hi);
    @(negedge clk); upd = 1'b1; low_in = lo; up_in = hi;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode), 0);
    chk("R1 gain", 32'(gain), 0);
    chk("R1 offs", 32'(offs), 0);
    chk("R1 sel", 32'(sel), 0);
    chk("R1 low", 32'(low_o), 127);
    chk("R1 up", 32'(up_o), 127);
    chk("R1 rdata", 32'(rdata), 0);
  endtask

  task automatic t_immediate();
    logic [7:0] d;
    h_start(8'h04); h_wr(8'hA5);
    chk("R4 mode direct", 32'(mode), 32'hA5);
    h_start(8'h04); h_rd(d);
    chk("R7 mode readback", 32'(d), 32'hA5);
  endtask

  task automatic t_vsync_wide();
    logic [7:0] d;
    h_start(8'h05); h_wr(8'hFA);
    chk("R2 gain after one byte", 32'(gain), 0);
    h_start(8'h05); h_rd(d);
    chk("R2 no readback change after one byte", 32'(d), 0);
    h_start(8'h05); h_wr(8'hFA); h_wr(8'h3C);
    chk("R5 gain waits for vsync", 32'(gain), 0);
    h_start(8'h05); h_rd(d);
    chk("R3 gain high byte masked", 32'(d), 32'h0A);
    h_rd(d);
    chk("R7 gain low byte before sync", 32'(d), 32'h3C);
    p_hs();
    chk("R5 hsync ignored by gain", 32'(gain), 0);
    p_vs();
    chk("R5 gain on vsync", 32'(gain), 32'hA3C);
  endtask

  task automatic t_hsync();
    logic [7:0] d;
    h_start(8'h06); h_wr(8'hFF); h_wr(8'hFF);
    chk("R6 offs waits", 32'(offs), 0);
    p_vs();
    chk("R6 vsync ignored by offs", 32'(offs), 0);
    p_hs();
    chk("R6 offs on hsync", 32'(offs), 32'h1FF);
    h_start(8'h06); h_rd(d);
    chk("R7 write-only high", 32'(d), 0);
    h_rd(d);
    chk("R7 write-only low", 32'(d), 0);
    h_start(8'h07); h_wr(8'hFF);
    chk("R6 sel waits", 32'(sel), 0);
    p_hs();
    chk("R6 sel on hsync", 32'(sel), 32'h1F);
    h_start(8'h07); h_rd(d);
    chk("R3 sel readback masked", 32'(d), 32'h1F);
  endtask

  task automatic t_status();
    logic [7:0] d;
    pic = 1'b1;
    p_upd(7'd5, 7'd9);
    chk("R8 low loaded", 32'(low_o), 5);
    h_start(8'h0C); h_rd(d);
    chk("R8 status high byte", 32'(d), 32'h89);
    chk("R9 low reload", 32'(low_o), 127);
    chk("R9 up reload", 32'(up_o), 127);
    p_upd(7'd3, 7'd4);
    h_rd(d);
    chk("R9 captured low byte", 32'(d), 32'h05);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    h_start(8'h0C); h_wr(8'h00); h_wr(8'h00);
    chk("R10 status write low", 32'(low_o), 3);
    chk("R10 status write up", 32'(up_o), 4);
    h_start(8'h30); h_wr(8'h77); h_wr(8'h66);
    chk("R10 unmapped write mode", 32'(mode), 32'hA5);
    h_start(8'h04); h_rd(d);
    chk("R10 unmapped write readback", 32'(d), 32'hA5);
    h_start(8'h30); h_rd(d);
    chk("R7 unmapped read", 32'(d), 0);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    h_start(8'h05); h_wr(8'h01);
    h_start(8'h05); h_rd(d);
    chk("R11 cut write no commit hi", 32'(d), 32'h0A);
    h_rd(d);
    chk("R11 cut write no commit lo", 32'(d), 32'h3C);
    h_start(8'h05); h_wr(8'h02); h_wr(8'h03);
    p_vs();
    chk("R11 restarted write", 32'(gain), 32'h203);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_immediate();
    t_vsync_wide();
    t_hsync();
    t_status();
    t_ignored();
    t_restart();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule